// File: doc/BRIEF.md
# Colour-Expanding Pixel Writer with Raster Operation

This block turns one 32-bit data word into a run of 8-bit pixels in a framebuffer held in a synchronous pixel RAM. A transfer starts at a pixel offset and covers a pixel count taken from the access size and a count field. For every pixel the block reads the old byte and merges a source byte into it through a raster operation. The block then writes the result back. Only the bits selected by the plane mask can change.

In expansion mode each data bit picks the foreground or the background colour. The bit order is most significant first: the highest bit used goes to the lowest address. Zero bits can be made transparent, and a per-pixel bitmask can stop a pixel from being written at all. In direct mode the four bytes of the word go to four consecutive pixels, most significant byte first.

The block also holds a position register. A transfer that asks for X increment moves this register forward. A transfer that would run past the end of the framebuffer is dropped and flagged with an error pulse.

Top module: `pxw_writer`

## Requirements
- R1: After reset `busy`, `err`, `ram_rd_en` and `ram_wr_en` are low and `pos` is zero.
- R2: The raster code is `op[11:8]`. Code 0 clears the masked bits. Code 3 puts the source into them. Code 6 XORs the source into them. Code 10 inverts them. Code 15 sets them. Every other code leaves the destination byte as it was.
- R3: A destination bit whose `plane_mask` bit is 0 never changes.
- R4: In expansion mode (`direct`=0) with count n, the pixel at `base+i` is controlled by data bit n-1-i. A 1 bit selects `fg`.
- R5: A 0 data bit writes `bg` only when `op[28]` and `op[1]` are both 0. Otherwise that pixel is left unchanged.
- R6: When `op[29]` is 1, a pixel is written only if its bitmask bit is 1. In expansion mode that bit has index n-1-i in an aligned mask. The aligned mask is `bitmask[31:24]` for byte access, `bitmask[31:16]` for halfword access and the full `bitmask` for word access.
- R7: `acc_size` is encoded as 0 = byte, 1 = halfword, 2 or 3 = word. In expansion mode the pixel count is 2 to the power `pix_field`, limited to 8, 16 or 32 for byte, halfword or word access.
- R8: In direct mode a transfer covers 4 pixels. Pixel `base+j` takes `data[31-8j -: 8]`. When `op[29]` is 1, pixel `base+j` is gated by `bitmask[31-j]`.
- R9: Pixel i is read in cycle i after the accepting edge and written one cycle later at the same address. `busy` is high from the cycle after `start` through the last write, which gives n+1 cycles. A `start` while `busy` is high is ignored.
- R10: A transfer with `base` + count > `FB_SIZE` makes no RAM access and does not move `pos`. It raises `err` for one cycle after the `start` edge. A transfer that ends exactly at `FB_SIZE` is accepted.
- R11: `pos_ld` loads `pos_din` into `pos`. An accepted transfer with `incr_x` high adds 4 × count to `pos`. Otherwise `pos` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a transfer (taken when idle) |
| base | input | ADDR_W | First pixel offset |
| acc_size | input | 2 | Access size code |
| pix_field | input | 4 | Log2 of pixels per transfer |
| direct | input | 1 | 1 = four bytes as pixels, 0 = colour expansion |
| incr_x | input | 1 | Advance the position register with this transfer |
| data | input | 32 | Data word |
| fg | input | 8 | Foreground colour |
| bg | input | 8 | Background colour |
| plane_mask | input | 8 | Bits that may change |
| op | input | 32 | Operation word (raster code, gating and transparency bits) |
| bitmask | input | 32 | Per-pixel write mask |
| pos_ld | input | 1 | Load the position register |
| pos_din | input | 32 | Load value for the position register |
| pos | output | 32 | Position register |
| busy | output | 1 | Transfer in progress |
| err | output | 1 | One-cycle pulse for a dropped transfer |
| ram_rd_en | output | 1 | Pixel RAM read enable |
| ram_rd_addr | output | ADDR_W | Pixel RAM read address |
| ram_rd_data | input | 8 | Pixel RAM read data, one cycle after the read |
| ram_wr_en | output | 1 | Pixel RAM write enable |
| ram_wr_addr | output | ADDR_W | Pixel RAM write address |
| ram_wr_data | output | 8 | Pixel RAM write data |

## Verification
The expansion path is driven with mixed 1/0 data words under copy. This separates a correct MSB-first order from a reversed one, and it shows whether 0 bits write `bg`. The same words are then run with each transparency bit set and with bitmask gating at all three access sizes, which exposes a mask taken from the wrong byte lanes or a count that is not limited. Each raster code is used with a partial plane mask over a known RAM pattern, so a wrong code and a leak outside the mask give different bytes. Direct-mode words with distinct bytes reveal byte-order swaps. Directed runs cover cycle timing, a start while busy, the exact end of the framebuffer and one pixel past it, and position updates.

// File: rtl/pxw_pkg.sv
package pxw_pkg;
  localparam int PIX_W  = 8;
  localparam int WORD_W = 32;
  localparam int CNT_W  = 6;   // holds a count of up to 32
  localparam int IDX_W  = 5;   // pixel index within a transfer

  localparam logic [3:0] ROP_CLEAR  = 4'd0;
  localparam logic [3:0] ROP_COPY   = 4'd3;
  localparam logic [3:0] ROP_XOR    = 4'd6;
  localparam logic [3:0] ROP_INVERT = 4'd10;
  localparam logic [3:0] ROP_SET    = 4'd15;

  localparam int OPB_GATE  = 29;
  localparam int OPB_KEEPA = 28;
  localparam int OPB_KEEPB = 1;

  // merge src into dst through the raster code, only inside pm
  function automatic logic [PIX_W-1:0] rop_apply(input logic [3:0] code,
                                                 input logic [PIX_W-1:0] dst,
                                                 input logic [PIX_W-1:0] src,
                                                 input logic [PIX_W-1:0] pm);
    case (code)
      ROP_CLEAR:  rop_apply = dst & ~pm;
      ROP_COPY:   rop_apply = (dst & ~pm) | (src & pm);
      ROP_XOR:    rop_apply = dst ^ (src & pm);
      ROP_INVERT: rop_apply = dst ^ pm;
      ROP_SET:    rop_apply = dst | pm;
      default:    rop_apply = dst;
    endcase
  endfunction

  // pixels covered by one transfer
  function automatic logic [CNT_W-1:0] xfer_count(input logic [1:0] sz,
                                                  input logic [3:0] fld,
                                                  input logic       dir);
    logic [15:0]      raw;
    logic [CNT_W-1:0] lim;
    raw = 16'd1 << fld;
    case (sz)
      2'd0:    lim = CNT_W'(8);
      2'd1:    lim = CNT_W'(16);
      default: lim = CNT_W'(32);
    endcase
    if (dir)                      xfer_count = CNT_W'(4);
    else if (raw > 16'(lim))      xfer_count = lim;
    else                          xfer_count = raw[CNT_W-1:0];
  endfunction

  // bitmask as seen by the pixel index in expansion mode
  function automatic logic [WORD_W-1:0] mask_align(input logic [1:0] sz,
                                                   input logic [WORD_W-1:0] bm,
                                                   input logic dir);
    if (dir)             mask_align = bm;
    else if (sz == 2'd0) mask_align = bm >> 24;
    else if (sz == 2'd1) mask_align = bm >> 16;
    else                 mask_align = bm;
  endfunction
endpackage

// File: rtl/pxw_rop.sv
module pxw_rop
  import pxw_pkg::*;
(
  input  logic [3:0]       code,
  input  logic [PIX_W-1:0] dst,
  input  logic [PIX_W-1:0] src,
  input  logic [PIX_W-1:0] pm,
  output logic [PIX_W-1:0] res
);
  assign res = rop_apply(code, dst, src, pm);
endmodule

// File: rtl/pxw_pixsel.sv
module pxw_pixsel
  import pxw_pkg::*;
(
  input  logic              dir,
  input  logic [IDX_W-1:0]  idx,
  input  logic [IDX_W-1:0]  last_idx,
  input  logic [WORD_W-1:0] data,
  input  logic [PIX_W-1:0]  fg,
  input  logic [PIX_W-1:0]  bg,
  input  logic              gate_on,
  input  logic              keep_zero,
  input  logic [WORD_W-1:0] bmask,
  output logic [PIX_W-1:0]  src,
  output logic              en
);
  localparam int LANES = WORD_W / PIX_W;

  logic [PIX_W-1:0] lane [LANES];
  logic [IDX_W-1:0] bit_pos;
  logic [IDX_W-1:0] dir_mpos;
  logic             data_bit;
  logic             mask_ok;

  // lane 0 is the most significant byte
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign lane[k] = data[WORD_W-1-PIX_W*k -: PIX_W];
  end

  assign bit_pos  = last_idx - idx;
  assign dir_mpos = IDX_W'(WORD_W-1) - idx;

  always_comb begin
    data_bit = data[bit_pos];
    if (dir) begin
      mask_ok = !gate_on || bmask[dir_mpos];
      src     = lane[idx[$clog2(LANES)-1:0]];
      en      = mask_ok;
    end else begin
      mask_ok = !gate_on || bmask[bit_pos];
      src     = data_bit ? fg : bg;
      en      = mask_ok && (data_bit || !keep_zero);
    end
  end
endmodule

// File: rtl/pxw_seq.sv
module pxw_seq
  import pxw_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [ADDR_W-1:0] base_q,
  input  logic [IDX_W-1:0]  last_idx,
  input  logic [PIX_W-1:0]  px_src,
  input  logic              px_en,
  output logic              issuing,
  output logic [IDX_W-1:0]  idx,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              last_issue,
  output logic              s2_valid,
  output logic [ADDR_W-1:0] s2_addr,
  output logic [PIX_W-1:0]  s2_src,
  output logic              s2_en
);
  assign rd_addr    = base_q + ADDR_W'(idx);
  assign last_issue = issuing && (idx == last_idx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      issuing  <= 1'b0;
      idx      <= '0;
      s2_valid <= 1'b0;
      s2_addr  <= '0;
      s2_src   <= '0;
      s2_en    <= 1'b0;
    end else begin
      if (go) begin
        issuing <= 1'b1;
        idx     <= '0;
      end else if (issuing) begin
        idx <= idx + 1'b1;
        if (last_issue) issuing <= 1'b0;
      end
      s2_valid <= issuing;
      if (issuing) begin
        s2_addr <= rd_addr;
        s2_src  <= px_src;
        s2_en   <= px_en;
      end else begin
        s2_en   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pxw_writer.sv
module pxw_writer
  import pxw_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int FB_SIZE = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] base,
  input  logic [1:0]        acc_size,
  input  logic [3:0]        pix_field,
  input  logic              direct,
  input  logic              incr_x,
  input  logic [31:0]       data,
  input  logic [7:0]        fg,
  input  logic [7:0]        bg,
  input  logic [7:0]        plane_mask,
  input  logic [31:0]       op,
  input  logic [31:0]       bitmask,
  input  logic              pos_ld,
  input  logic [31:0]       pos_din,
  output logic [31:0]       pos,
  output logic              busy,
  output logic              err,
  output logic              ram_rd_en,
  output logic [ADDR_W-1:0] ram_rd_addr,
  input  logic [7:0]        ram_rd_data,
  output logic              ram_wr_en,
  output logic [ADDR_W-1:0] ram_wr_addr,
  output logic [7:0]        ram_wr_data
);
  localparam int EXT_W = ADDR_W + CNT_W + 1;

  // transfer fields captured on acceptance
  logic [ADDR_W-1:0] base_q;
  logic [IDX_W-1:0]  last_q;
  logic              dir_q;
  logic [WORD_W-1:0] data_q;
  logic [PIX_W-1:0]  fg_q, bg_q, pm_q;
  logic [3:0]        code_q;
  logic              gate_q, keep_q;
  logic [WORD_W-1:0] bm_q;

  // named events
  logic [CNT_W-1:0]  cnt_now;
  logic [EXT_W-1:0]  end_ext;
  logic              in_bounds;
  logic              accept;
  logic              reject;

  logic              issuing, last_issue;
  logic [IDX_W-1:0]  idx;
  logic [PIX_W-1:0]  px_src, s2_src, rop_out;
  logic              px_en, s2_valid, s2_en;
  logic [ADDR_W-1:0] rd_addr, s2_addr;

  assign cnt_now   = xfer_count(acc_size, pix_field, direct);
  assign end_ext   = EXT_W'(base) + EXT_W'(cnt_now);
  assign in_bounds = end_ext <= EXT_W'(FB_SIZE);
  assign busy      = issuing || s2_valid;
  assign accept    = start && !busy && in_bounds;
  assign reject    = start && !busy && !in_bounds;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      last_q <= '0;
      dir_q  <= 1'b0;
      data_q <= '0;
      fg_q   <= '0;
      bg_q   <= '0;
      pm_q   <= '0;
      code_q <= '0;
      gate_q <= 1'b0;
      keep_q <= 1'b0;
      bm_q   <= '0;
      err    <= 1'b0;
      pos    <= '0;
    end else begin
      err <= reject;
      if (accept) begin
        base_q <= base;
        last_q <= IDX_W'(cnt_now - CNT_W'(1));
        dir_q  <= direct;
        data_q <= data;
        fg_q   <= fg;
        bg_q   <= bg;
        pm_q   <= plane_mask;
        code_q <= op[11:8];
        gate_q <= op[OPB_GATE];
        keep_q <= op[OPB_KEEPA] | op[OPB_KEEPB];
        bm_q   <= mask_align(acc_size, bitmask, direct);
      end
      if (pos_ld)
        pos <= pos_din;
      else if (accept && incr_x)
        pos <= pos + {24'd0, cnt_now, 2'b00};
    end
  end

  pxw_pixsel u_sel (
    .dir      (dir_q),
    .idx      (idx),
    .last_idx (last_q),
    .data     (data_q),
    .fg       (fg_q),
    .bg       (bg_q),
    .gate_on  (gate_q),
    .keep_zero(keep_q),
    .bmask    (bm_q),
    .src      (px_src),
    .en       (px_en)
  );

  pxw_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (accept),
    .base_q    (base_q),
    .last_idx  (last_q),
    .px_src    (px_src),
    .px_en     (px_en),
    .issuing   (issuing),
    .idx       (idx),
    .rd_addr   (rd_addr),
    .last_issue(last_issue),
    .s2_valid  (s2_valid),
    .s2_addr   (s2_addr),
    .s2_src    (s2_src),
    .s2_en     (s2_en)
  );

  pxw_rop u_rop (
    .code(code_q),
    .dst (ram_rd_data),
    .src (s2_src),
    .pm  (pm_q),
    .res (rop_out)
  );

  assign ram_rd_en   = issuing;
  assign ram_rd_addr = rd_addr;
  assign ram_wr_en   = s2_valid && s2_en;
  assign ram_wr_addr = s2_addr;
  assign ram_wr_data = rop_out;
endmodule

// File: rtl/pxw_chk.sv
module pxw_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              accept,
  input logic              reject,
  input logic              incr_x,
  input logic              pos_ld,
  input logic [ADDR_W-1:0] base,
  input logic              busy,
  input logic              err,
  input logic [31:0]       pos,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [7:0]        rd_data,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [7:0]        wr_data,
  input logic [7:0]        pm_q
);
  assert_first_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy && rd_en && (rd_addr == $past(base)));

  assert_write_follows_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(rd_en) && (wr_addr == $past(rd_addr)));

  assert_plane_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (((wr_data ^ rd_data) & ~pm_q) == 8'h00));

  assert_drop_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> err && !busy && !rd_en);

  assert_err_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !busy && !wr_en);

  assert_pos_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!pos_ld && !(accept && incr_x)) |=> $stable(pos));

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !rd_en && !wr_en);
endmodule

bind pxw_writer pxw_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .accept (accept),
  .reject (reject),
  .incr_x (incr_x),
  .pos_ld (pos_ld),
  .base   (base),
  .busy   (busy),
  .err    (err),
  .pos    (pos),
  .rd_en  (ram_rd_en),
  .rd_addr(ram_rd_addr),
  .rd_data(ram_rd_data),
  .wr_en  (ram_wr_en),
  .wr_addr(ram_wr_addr),
  .wr_data(ram_wr_data),
  .pm_q   (pm_q)
);

// File: tb/sim_pxw_writer.sv
`timescale 1ns/1ps
module sim_pxw_writer;
  localparam int AW  = 8;
  localparam int FBS = 256;
  localparam int NV  = 16;

  typedef struct packed {
    logic [7:0]  base;
    logic [1:0]  sz;
    logic [3:0]  fld;
    logic        dir;
    logic [31:0] data;
    logic [7:0]  fg;
    logic [7:0]  bg;
    logic [7:0]  pm;
    logic [31:0] op;
    logic [31:0] bm;
  } vec_t;

  // base, size, field, direct, data, fg, bg, plane mask, op, bitmask
  localparam vec_t VEC [NV] = '{
    '{8'd16,  2'd2, 4'd3,  1'b0, 32'h000000B4, 8'h3C, 8'hC3, 8'hFF, 32'h00000300, 32'h00000000}, // R4 R5
    '{8'd32,  2'd2, 4'd3,  1'b0, 32'h000000B4, 8'h3C, 8'hC3, 8'hFF, 32'h00000302, 32'h00000000}, // R5 bit1
    '{8'd48,  2'd2, 4'd3,  1'b0, 32'h0000005A, 8'h3C, 8'hC3, 8'hFF, 32'h10000300, 32'h00000000}, // R5 bit28
    '{8'd64,  2'd2, 4'd3,  1'b0, 32'h0000000F, 8'h11, 8'h22, 8'hFF, 32'h20000300, 32'h000000C6}, // R6 word
    '{8'd80,  2'd1, 4'd5,  1'b0, 32'h0000C3A5, 8'h44, 8'h99, 8'hFF, 32'h20000300, 32'hA5F00000}, // R6 R7 half
    '{8'd100, 2'd0, 4'd4,  1'b0, 32'h00000096, 8'h5E, 8'hE5, 8'hFF, 32'h20000300, 32'h69000000}, // R6 R7 byte
    '{8'd120, 2'd2, 4'd5,  1'b0, 32'hF0F01234, 8'hA6, 8'h6A, 8'h0F, 32'h00000600, 32'h00000000}, // R2 xor R3
    '{8'd160, 2'd2, 4'd2,  1'b0, 32'h0000000A, 8'h00, 8'h00, 8'hF0, 32'h00000000, 32'h00000000}, // R2 clear R3
    '{8'd170, 2'd2, 4'd3,  1'b0, 32'h00000000, 8'h00, 8'h00, 8'hFF, 32'h00000A00, 32'h00000000}, // R2 invert
    '{8'd180, 2'd2, 4'd3,  1'b0, 32'h000000FF, 8'h00, 8'h00, 8'h3C, 32'h00000F00, 32'h00000000}, // R2 set R3
    '{8'd190, 2'd2, 4'd3,  1'b0, 32'h000000A5, 8'h12, 8'h34, 8'hFF, 32'h00000500, 32'h00000000}, // R2 other code
    '{8'd200, 2'd2, 4'd0,  1'b1, 32'h11223344, 8'h00, 8'h00, 8'hFF, 32'h00000300, 32'h00000000}, // R8
    '{8'd210, 2'd2, 4'd0,  1'b1, 32'h55667788, 8'h00, 8'h00, 8'hFF, 32'h20000300, 32'hA0000000}, // R8 gated
    '{8'd220, 2'd2, 4'd0,  1'b0, 32'h00000001, 8'h77, 8'h88, 8'hFF, 32'h00000300, 32'h00000000}, // R7 one pixel
    '{8'd224, 2'd0, 4'd15, 1'b0, 32'h000000C9, 8'hD1, 8'h1D, 8'hFF, 32'h00000300, 32'h00000000}, // R7 limit
    '{8'd248, 2'd2, 4'd3,  1'b0, 32'h0000003C, 8'hEE, 8'h01, 8'hFF, 32'h00000300, 32'h00000000}  // R10 edge
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] base = '0;
  logic [1:0]    acc_size = '0;
  logic [3:0]    pix_field = '0;
  logic          direct = 1'b0;
  logic          incr_x = 1'b0;
  logic [31:0]   data = '0;
  logic [7:0]    fg = '0, bg = '0, plane_mask = '0;
  logic [31:0]   op = '0, bitmask = '0;
  logic          pos_ld = 1'b0;
  logic [31:0]   pos_din = '0;
  logic [31:0]   pos;
  logic          busy, err;
  logic          ram_rd_en, ram_wr_en;
  logic [AW-1:0] ram_rd_addr, ram_wr_addr;
  logic [7:0]    ram_rd_data = '0;
  logic [7:0]    ram_wr_data;

  logic [7:0]    mem [FBS];
  logic [7:0]    expv [FBS];
  logic          preset_req = 1'b0;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  pxw_writer #(.ADDR_W(AW), .FB_SIZE(FBS)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .base(base), .acc_size(acc_size),
    .pix_field(pix_field), .direct(direct), .incr_x(incr_x), .data(data),
    .fg(fg), .bg(bg), .plane_mask(plane_mask), .op(op), .bitmask(bitmask),
    .pos_ld(pos_ld), .pos_din(pos_din), .pos(pos), .busy(busy), .err(err),
    .ram_rd_en(ram_rd_en), .ram_rd_addr(ram_rd_addr), .ram_rd_data(ram_rd_data),
    .ram_wr_en(ram_wr_en), .ram_wr_addr(ram_wr_addr), .ram_wr_data(ram_wr_data)
  );

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 13 + 90) & 255);
  endfunction

  // pixel RAM model: one-cycle read latency, optional preset
  always @(posedge clk) begin
    if (preset_req) begin
      for (int a = 0; a < FBS; a++) mem[a] <= pat(a);
    end else begin
      if (ram_rd_en) ram_rd_data <= mem[ram_rd_addr];
      if (ram_wr_en) mem[ram_wr_addr] <= ram_wr_data;
    end
  end

  function automatic int ref_count(input vec_t v);
    int n;
    int lim;
    if (v.dir) return 4;
    n = 1;
    for (int k = 0; k < 16; k++) if (k < int'(v.fld)) n = n * 2;
    lim = (v.sz == 2'd0) ? 8 : (v.sz == 2'd1) ? 16 : 32;
    return (n > lim) ? lim : n;
  endfunction

  function automatic logic [7:0] ref_px(input vec_t v, input int i, input logic [7:0] old);
    int          n;
    int          bp;
    logic        wr;
    logic [7:0]  s;
    logic [7:0]  res;
    logic [31:0] mw;
    n = ref_count(v);
    if (v.dir) begin
      s  = v.data[8*(3-i) +: 8];
      wr = !v.op[29] || v.bm[31-i];
    end else begin
      case (v.sz)
        2'd0:    mw = {24'd0, v.bm[31:24]};
        2'd1:    mw = {16'd0, v.bm[31:16]};
        default: mw = v.bm;
      endcase
      bp = n - 1 - i;
      if (v.data[bp]) begin
        s  = v.fg;
        wr = !v.op[29] || mw[bp];
      end else begin
        s  = v.bg;
        wr = (!v.op[29] || mw[bp]) && !v.op[28] && !v.op[1];
      end
    end
    if (!wr) return old;
    res = old;
    for (int b = 0; b < 8; b++) begin
      if (v.pm[b]) begin
        case (v.op[11:8])
          4'd0:    res[b] = 1'b0;
          4'd3:    res[b] = s[b];
          4'd6:    res[b] = old[b] ^ s[b];
          4'd10:   res[b] = ~old[b];
          4'd15:   res[b] = 1'b1;
          default: res[b] = old[b];
        endcase
      end
    end
    return res;
  endfunction

  task automatic check(input string req, input logic ok, input longint act, input longint expd);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expd);
    end
  endtask

  task automatic preset();
    @(negedge clk); preset_req = 1'b1;
    @(negedge clk); preset_req = 1'b0;
    for (int a = 0; a < FBS; a++) expv[a] = pat(a);
  endtask

  task automatic drive(input vec_t v, input logic ix);
    base = v.base; acc_size = v.sz; pix_field = v.fld; direct = v.dir;
    data = v.data; fg = v.fg; bg = v.bg; plane_mask = v.pm; op = v.op;
    bitmask = v.bm; incr_x = ix;
  endtask

  task automatic run(input vec_t v, input logic ix);
    @(negedge clk); drive(v, ix); start = 1'b1;
    @(negedge clk); start = 1'b0; incr_x = 1'b0;
    while (busy) @(negedge clk);
  endtask

  task automatic cmp_mem(input string req);
    int bad;
    bad = 0;
    for (int a = 0; a < FBS; a++) begin
      if (mem[a] !== expv[a]) begin
        if (bad == 0) $display("FAIL %s addr=%0d actual=%0h expected=%0h", req, a, mem[a], expv[a]);
        bad++;
      end
    end
    n_chk++;
    if (bad != 0) n_bad++;
  endtask

  initial begin
    #4000000;
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] pos_before;
    int          cyc;
    vec_t        v;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", busy === 1'b0 && err === 1'b0 && ram_rd_en === 1'b0 && ram_wr_en === 1'b0 && pos === 32'd0,
          {busy, err, ram_rd_en, ram_wr_en, pos}, 0);

    // vector table (R2 R3 R4 R5 R6 R7 R8, R10 boundary)
    for (int k = 0; k < NV; k++) begin
      preset();
      for (int i = 0; i < ref_count(VEC[k]); i++)
        expv[VEC[k].base + i] = ref_px(VEC[k], i, expv[VEC[k].base + i]);
      run(VEC[k], 1'b0);
      cmp_mem($sformatf("vector%0d R2-R8", k));
    end

    // R9 timing of an 8-pixel transfer, and a start while busy is ignored
    preset();
    v = VEC[0];
    v.base = 8'd40;
    for (int i = 0; i < 8; i++) expv[40 + i] = ref_px(v, i, expv[40 + i]);
    pos_before = pos;
    @(negedge clk); drive(v, 1'b0); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check("R9 first read", busy === 1'b1 && ram_rd_en === 1'b1 && ram_rd_addr === 8'd40 && ram_wr_en === 1'b0,
          {busy, ram_rd_en, ram_rd_addr, ram_wr_en}, {1'b1, 1'b1, 8'd40, 1'b0});
    cyc = 1;
    @(negedge clk);
    check("R9 first write", ram_wr_en === 1'b1 && ram_wr_addr === 8'd40 && ram_rd_addr === 8'd41,
          {ram_wr_en, ram_wr_addr, ram_rd_addr}, {1'b1, 8'd40, 8'd41});
    cyc = 2;
    base = 8'd200; incr_x = 1'b1; start = 1'b1;
    @(negedge clk); start = 1'b0; incr_x = 1'b0;
    cyc = 3;
    while (busy) begin @(negedge clk); cyc++; end
    check("R9 busy span", cyc == 9 + 1, cyc - 1, 9);
    cmp_mem("R9 ignored start");
    check("R9 pos after ignored start", pos === pos_before, pos, pos_before);

    // R10 dropped transfer past the end
    preset();
    v = VEC[15];
    v.base = 8'd250;
    pos_before = pos;
    @(negedge clk); drive(v, 1'b1); start = 1'b1;
    @(negedge clk); start = 1'b0; incr_x = 1'b0;
    check("R10 err pulse", err === 1'b1 && busy === 1'b0 && ram_rd_en === 1'b0,
          {err, busy, ram_rd_en}, {1'b1, 1'b0, 1'b0});
    @(negedge clk);
    check("R10 err one cycle", err === 1'b0, err, 0);
    cmp_mem("R10 no write");
    check("R10 pos unchanged", pos === pos_before, pos, pos_before);

    // R11 position register
    @(negedge clk); pos_ld = 1'b1; pos_din = 32'h0000_0100;
    @(negedge clk); pos_ld = 1'b0;
    check("R11 load", pos === 32'h100, pos, 32'h100);
    run(VEC[0], 1'b1);
    check("R11 incr expand", pos === 32'h120, pos, 32'h120);
    run(VEC[11], 1'b1);
    check("R11 incr direct", pos === 32'h130, pos, 32'h130);
    run(VEC[13], 1'b0);
    check("R11 no incr", pos === 32'h130, pos, 32'h130);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule